// File: doc/BRIEF.md
# Banked GPIO Register File with Masked Output Writes

This block holds the software-visible state of a multi-bank general-purpose I/O controller. Each bank has up to 32 pins, and the width of each bank is set by a parameter. A bank holds three registers: an output value, a direction and an output enable. Software reaches them through a plain 32-bit register bus made of a byte address, write data, a write strobe and combinational read data. Single pins can be driven without a read-modify-write sequence. Two write-only registers per bank each carry a 16-bit keep-mask in the upper half and 16 data bits in the lower half. One of them covers pins 0 to 15 and the other covers pins 16 to 31.

Each pin leaves the block as an output value and a tri-state enable. A pin is driven only when both its direction bit and its output-enable bit are set. The pin levels seen at the pads pass through a two-stage synchronizer and can be read from a read-only input register at a separate address. In bank 0, a parameterised set of pins (7 and 8 by default) are output-only: their direction bits always read as 1 and cannot be cleared.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset, every output-value and output-enable bit is 0, so pin_oe and pin_out are all 0, and every direction bit is 0 except the fixed output-only pins of bank 0.
- R2: A write to the low masked register at byte address 8*b replaces output bit i (i in 0..15) of bank b with wdata[i] where wdata[16+i] is 0, and leaves it unchanged where wdata[16+i] is 1.
- R3: A write to the high masked register at byte address 8*b+4 replaces output bit 16+i of bank b with wdata[i] where wdata[16+i] is 0, and leaves it unchanged where wdata[16+i] is 1.
- R4: A read of either masked register returns 0.
- R5: The input register at byte address 0x60+4*b returns the pin levels of bank b, one bit per pin. A level change at pin_in is first visible two clock edges later.
- R6: The direction register at byte address 0x204+0x40*b is read/write, with 1 meaning output and 0 meaning input.
- R7: The output-enable register at byte address 0x208+0x40*b is read/write. pin_oe of a pin is 1 only when both its direction bit and its output-enable bit are 1.
- R8: Bits at or above a bank's width read as 0 in every register, ignore writes, and keep pin_out and pin_oe at 0.
- R9: In bank 0, the direction bits of the pins in BANK0_OUT_ONLY (default pins 7 and 8) always read as 1, including after reset and after a write of 0.
- R10: pin_out of bank b, bits 32*b upward, equals that bank's output-value register. A write takes effect on pin_out one clock edge after the write is sampled.
- R11: Addresses that map to no register read as 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pin_in | input | 32*NUM_BANKS | Pad levels, 32 slots per bank |
| pin_out | output | 32*NUM_BANKS | Output value per pin |
| pin_oe | output | 32*NUM_BANKS | Tri-state enable per pin |

## Verification
A fault in the output, direction or enable state shows up at pin_out or pin_oe at the first clock edge after the write that caused it. The same fault shows up at once on bus_rdata when the register is read. For that reason the bench compares the pins and the readback after every write, against its own bank model. A synchronizer with the wrong depth shows up as a readback that changes one edge too early or one edge too late. Width masking and the fixed direction bits are checked by writing all-ones and all-zero patterns and reading them back.

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs #(
  parameter int          NUM_BANKS = 4,
  parameter int          BANK_WIDTH [NUM_BANKS] = '{32, 22, 32, 32},
  parameter logic [31:0] BANK0_OUT_ONLY = 32'h0000_0180,
  parameter int          ADDR_W = 12
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [31:0]               bus_wdata,
  input  logic                      bus_we,
  output logic [31:0]               bus_rdata,
  input  logic [32*NUM_BANKS-1:0]   pin_in,
  output logic [32*NUM_BANKS-1:0]   pin_out,
  output logic [32*NUM_BANKS-1:0]   pin_oe
);
  localparam int NPIN = 32 * NUM_BANKS;

  function automatic logic [31:0] width_mask(input int w);
    return (w >= 32) ? 32'hFFFF_FFFF : ((32'h1 << w) - 32'h1);
  endfunction

  logic [NPIN-1:0] sync1, sync2;
  logic [31:0]     rd_part [NUM_BANKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
    end else begin
      sync1 <= pin_in;
      sync2 <= sync1;
    end
  end

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [31:0] WM  = width_mask(BANK_WIDTH[b]);
    localparam logic [31:0] FIX = (b == 0) ? (BANK0_OUT_ONLY & WM) : 32'h0;
    localparam logic [ADDR_W-1:0] A_LO  = ADDR_W'(8 * b);
    localparam logic [ADDR_W-1:0] A_HI  = ADDR_W'(8 * b + 4);
    localparam logic [ADDR_W-1:0] A_IN  = ADDR_W'(32'h60 + 4 * b);
    localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(32'h204 + 32'h40 * b);
    localparam logic [ADDR_W-1:0] A_OE  = ADDR_W'(32'h208 + 32'h40 * b);

    logic [31:0] out_r, dir_r, oe_r;
    wire  [15:0] keep = bus_wdata[31:16];
    wire  [15:0] val  = bus_wdata[15:0] & ~keep;
    wire hit_lo  = bus_we && bus_addr == A_LO;
    wire hit_hi  = bus_we && bus_addr == A_HI;
    wire hit_dir = bus_we && bus_addr == A_DIR;
    wire hit_oe  = bus_we && bus_addr == A_OE;

    always_ff @(posedge clk) begin
      if (rst) begin
        out_r <= '0;
        dir_r <= FIX;
        oe_r  <= '0;
      end else begin
        if (hit_lo)  out_r <= ((out_r & {16'hFFFF, keep}) | {16'h0, val}) & WM;
        if (hit_hi)  out_r <= ((out_r & {keep, 16'hFFFF}) | {val, 16'h0}) & WM;
        if (hit_dir) dir_r <= (bus_wdata & WM) | FIX;
        if (hit_oe)  oe_r  <= bus_wdata & WM;
      end
    end

    assign pin_out[32*b +: 32] = out_r;
    assign pin_oe[32*b +: 32]  = dir_r & oe_r;

    assign rd_part[b] = (bus_addr == A_IN)  ? (sync2[32*b +: 32] & WM) :
                        (bus_addr == A_DIR) ? dir_r :
                        (bus_addr == A_OE)  ? oe_r  : 32'h0;

    assert_lo_keep_R2: assert property (@(posedge clk) disable iff (rst)
      (hit_lo && keep == 16'hFFFF) |=> $stable(pin_out[32*b +: 16]));
    assert_hi_keep_R3: assert property (@(posedge clk) disable iff (rst)
      (hit_hi && keep == 16'hFFFF) |=> $stable(pin_out[32*b+16 +: 16]));
    assert_masked_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
      (bus_addr == A_LO || bus_addr == A_HI) |-> bus_rdata == 32'h0);
    assert_above_width_zero_R8: assert property (@(posedge clk) disable iff (rst)
      (bus_addr == A_DIR || bus_addr == A_OE || bus_addr == A_IN) |-> (bus_rdata & ~WM) == 32'h0);
    if (b == 0) begin : g_fix
      assert_fixed_dir_R9: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_DIR) |-> (bus_rdata & FIX) == FIX);
    end
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_BANKS; i++) bus_rdata = bus_rdata | rd_part[i];
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    $fell(rst) |-> (pin_oe == '0 && pin_out == '0));
endmodule

// File: tb/gpio_bank_regs_bench.sv
`timescale 1ns/1ps
module gpio_bank_regs_bench;
  localparam int NB = 4;
  localparam int WID [NB] = '{32, 22, 32, 32};
  localparam logic [31:0] FIXED = 32'h0000_0180;

  logic clk = 0, rst = 1;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic bus_we = 0;
  logic [31:0] bus_rdata;
  logic [32*NB-1:0] pin_in, pin_out, pin_oe, ext = '0;

  assign pin_in = (pin_oe & pin_out) | (~pin_oe & ext);

  gpio_bank_regs u_gpio_bank_regs (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_we(bus_we),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe));

  always #4 clk = ~clk;

  int checks = 0, fails = 0;
  logic [31:0] seed = 32'h1234_5678;
  logic [31:0] m_out [NB], m_dir [NB], m_oe [NB];

  function automatic logic [31:0] wm(input int b);
    return (WID[b] >= 32) ? 32'hFFFF_FFFF : ((32'h1 << WID[b]) - 1);
  endfunction
  function automatic logic [31:0] fx(input int b);
    return (b == 0) ? (FIXED & wm(0)) : 32'h0;
  endfunction

  task automatic rnd(output logic [31:0] r);
    seed = seed ^ (seed << 13); seed = seed ^ (seed >> 17); seed = seed ^ (seed << 5);
    r = seed;
  endtask
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask
  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(negedge clk); bus_we = 0;
  endtask
  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; #1; d = bus_rdata;
  endtask
  task automatic pins_check(input int b);
    chk(pin_out[32*b +: 32] == m_out[b], "R10", pin_out[32*b +: 32], m_out[b]);
    chk(pin_oe[32*b +: 32] == (m_dir[b] & m_oe[b]), "R7", pin_oe[32*b +: 32], m_dir[b] & m_oe[b]);
  endtask

  initial begin
    #(200000 * 8);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [31:0] r, d, m, exp;
    repeat (3) @(negedge clk);
    rst = 0;
    for (int b = 0; b < NB; b++) begin
      m_out[b] = 0; m_dir[b] = fx(b); m_oe[b] = 0;
    end
    // R1 reset state
    @(negedge clk);
    chk(pin_oe == '0, "R1", pin_oe[31:0], 0);
    chk(pin_out == '0, "R1", pin_out[31:0], 0);
    for (int b = 0; b < NB; b++) begin
      rd(12'h204 + 12'(b * 64), r); chk(r == fx(b), "R1 R9", r, fx(b));
      rd(12'h208 + 12'(b * 64), r); chk(r == 0, "R1", r, 0);
    end
    // R6 R7 R8 R9 direction / enable sweeps
    for (int b = 0; b < NB; b++) begin
      for (int k = 0; k < 6; k++) begin
        rnd(d);
        if (k == 0) d = 32'h0;
        if (k == 1) d = 32'hFFFF_FFFF;
        wr(12'h204 + 12'(b * 64), d); m_dir[b] = (d & wm(b)) | fx(b);
        rnd(d);
        if (k == 1) d = 32'hFFFF_FFFF;
        wr(12'h208 + 12'(b * 64), d); m_oe[b] = d & wm(b);
        rd(12'h204 + 12'(b * 64), r); chk(r == m_dir[b], "R6 R8 R9", r, m_dir[b]);
        rd(12'h208 + 12'(b * 64), r); chk(r == m_oe[b], "R7 R8", r, m_oe[b]);
        pins_check(b);
      end
    end
    // R2 R3 R4 masked writes
    for (int b = 0; b < NB; b++) begin
      for (int h = 0; h < 2; h++) begin
        for (int k = 0; k < 8; k++) begin
          rnd(m); rnd(d);
          if (k == 0) m = 32'h0;
          if (k == 1) m = 32'hFFFF_FFFF;
          if (k == 2) begin m = 32'hFFFF_0000; d = 32'hFFFF; end
          d = {m[15:0], d[15:0]};
          wr(12'(8 * b + 4 * h), d);
          if (h == 0) m_out[b] = ((m_out[b] & {16'hFFFF, m[15:0]}) | {16'h0, d[15:0] & ~m[15:0]}) & wm(b);
          else        m_out[b] = ((m_out[b] & {m[15:0], 16'hFFFF}) | {d[15:0] & ~m[15:0], 16'h0}) & wm(b);
          chk(pin_out[32*b +: 32] == m_out[b], h ? "R3 R8" : "R2 R8", pin_out[32*b +: 32], m_out[b]);
          rd(12'(8 * b + 4 * h), r); chk(r == 0, "R4", r, 0);
        end
        pins_check(b);
      end
    end
    // R5 readback with synchronizer latency
    for (int k = 0; k < 6; k++) begin
      for (int b = 0; b < NB; b++) begin
        rnd(d); ext[32*b +: 32] = d;
      end
      repeat (3) @(negedge clk);
      for (int b = 0; b < NB; b++) begin
        exp = ((m_dir[b] & m_oe[b] & m_out[b]) | (~(m_dir[b] & m_oe[b]) & ext[32*b +: 32])) & wm(b);
        rd(12'h060 + 12'(4 * b), r); chk(r == exp, "R5 R8", r, exp);
      end
    end
    // R5 latency: bank 3 with nothing driven
    wr(12'h208 + 12'(3 * 64), 32'h0); m_oe[3] = 0;
    bus_addr = 12'h06C;
    @(negedge clk); ext[96 +: 32] = 32'h0; repeat (3) @(negedge clk);
    ext[96 +: 32] = 32'hA5A5_5A5A;
    @(negedge clk); #1 chk(bus_rdata == 32'h0, "R5 one edge", bus_rdata, 0);
    @(negedge clk); #1 chk(bus_rdata == 32'hA5A5_5A5A, "R5 two edges", bus_rdata, 32'hA5A5_5A5A);
    // R11 unmapped addresses
    wr(12'h020, 32'h0000_FFFF); wr(12'h070, 32'hFFFF_FFFF); wr(12'h200, 32'hFFFF_FFFF);
    rd(12'h020, r); chk(r == 0, "R11", r, 0);
    rd(12'h070, r); chk(r == 0, "R11", r, 0);
    rd(12'h200, r); chk(r == 0, "R11", r, 0);
    for (int b = 0; b < NB; b++) begin
      pins_check(b);
      rd(12'h204 + 12'(b * 64), r); chk(r == m_dir[b], "R11", r, m_dir[b]);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule